// File: doc/BRIEF.md
# Serial ADC Readout Sequencer

This block is the master side of one conversion-and-read transaction with an eight-channel serial successive-approximation converter. The converter's own serial clock drives its conversion. A one-cycle start request latches a 3-bit channel, a single-ended/differential flag, a unipolar/bipolar flag, a sign-extension request, an SCLK half-period setting and an idle-gap length. The block then selects the converter, sends a command byte, and clocks in two more bytes while sending zeros. It returns the 10-bit code with a one-cycle done pulse.

SCLK is derived from the system clock. Each half-period lasts `half_div + 1` system cycles, so a 125 MHz system clock covers 100 kHz to 2 MHz. An idle gap of `gap_cycles + 1` system cycles is inserted after the first and the second byte. The converter holds its sample only for a limited time, so a watchdog counts system cycles from the end of the command byte. If the count reaches `TMO_CYC` before the last result bit is in, the transaction is cut short and flagged.

Top module: `sar_adc_reader`

## Requirements
- R1: The command byte is, from MSB to LSB: a 1, the three channel bits (MSB first), the unipolar flag, the single-ended flag, and two 1s. It goes out on `adc_din` MSB first, and `adc_din` changes only in the cycle SCLK falls or while SCLK is low.
- R2: While idle, `adc_cs_n` is high and `adc_sclk` is low. SCLK is never high while chip select is high. Chip select falls one edge after start is accepted and stays low for exactly one half-period before the first SCLK rise.
- R3: With H = half_div + 1, the SCLK period inside a byte is 2·H system cycles. The divider value is latched when start is accepted.
- R4: A complete transaction gives exactly 24 SCLK rising edges, in three bytes of eight. `adc_din` is 0 during the second and third bytes.
- R5: `adc_dout` is sampled on each SCLK rise. The first received byte is discarded. The result code is bits 14 down to 5 of the 16 bits received in the second and third bytes, taken as one word with the earliest bit as MSB. The leading bit, the two sub-bits and the three trailing bits are ignored.
- R6: `result` zero-extends the code to OUT_W bits. The one exception is bipolar mode (unipolar flag 0) with `sext_en` set, where the code's bit 9 fills the upper bits.
- R7: `busy` is high from the edge that accepts start. `done` is a one-cycle pulse, and `busy` falls at the same edge. With G = gap_cycles, a complete transaction raises `done` at the 48·H + 2·G + 2-th edge after the accepting edge.
- R8: A start request while busy is ignored. The latched command does not change, the transaction runs its normal length, and no extra transaction follows.
- R9: The watchdog opens when the command byte ends. If 32·H + 2·G + 2 exceeds TMO_CYC, the transaction is aborted at the 16·H + TMO_CYC-th edge after start. On abort, `done` and `tmo_err` pulse together, `result` is 0, chip select goes high and SCLK goes low. Otherwise `tmo_err` stays 0.
- R10: After reset, `adc_cs_n` is 1, and `adc_sclk`, `busy`, `done` and `tmo_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle transaction request |
| chan | input | 3 | Channel select |
| single_ended | input | 1 | 1 = single-ended input, 0 = differential |
| unipolar | input | 1 | 1 = unipolar (straight binary), 0 = bipolar (two's complement) |
| sext_en | input | 1 | Sign-extend bipolar results |
| half_div | input | DIV_W | SCLK half-period minus one, in system cycles |
| gap_cycles | input | GAP_W | Idle gap after bytes one and two, minus one, in system cycles |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Serial data to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Watchdog abort, valid with done |
| result | output | OUT_W | Extracted, optionally sign-extended code |

## Verification
Each outcome has a fixed edge count from the edge that accepts start. `busy` is due after that edge. `done` and `result` are due after edge 48·H + 2·G + 2, or after edge 16·H + TMO_CYC on a watchdog abort. The bench counts system-clock edges from the accepting edge and reads outputs 2 ns after each edge. It checks that `done` first appears at exactly the predicted count. It also checks SCLK timing in absolute time against 8·H and 16·H ns, and the result-window boundary at gaps of 435 and 436 cycles.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  localparam int CH_W     = 3;
  localparam int CMD_W    = 8;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 10;
  localparam int CODE_LSB = 5;
  localparam int BYTES    = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } rd_state_t;

  // command byte: start bit, channel, unipolar, single-ended, external-clock pair
  function automatic logic [CMD_W-1:0] mk_cmd(input logic [CH_W-1:0] ch,
                                              input logic uni,
                                              input logic se);
    mk_cmd = {1'b1, ch, uni, se, 2'b11};
  endfunction

  // pull the conversion code out of the two received bytes
  function automatic logic [CODE_W-1:0] code_of(input logic [FRAME_W-1:0] fr);
    code_of = fr[CODE_LSB +: CODE_W];
  endfunction

endpackage

// File: rtl/sar_rd_halfgen.sv
module sar_rd_halfgen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || cnt == half_len) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = !restart && (cnt == half_len);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> cnt <= half_len);

endmodule

// File: rtl/sar_rd_shifter.sv
module sar_rd_shifter #(
  parameter int TX_W = 8,
  parameter int RX_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TX_W-1:0] load_val,
  input  logic            shift,
  input  logic            sample,
  input  logic            rx_bit,
  output logic            tx_bit,
  output logic [RX_W-1:0] rx_word
);

  logic [TX_W-1:0] tx_q;

  // zeros fill in behind the command, so later bytes send 0x00
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_val;
    end else if (shift) begin
      tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end
  end

  // only the last RX_W bits survive: the first byte falls off the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
    end else if (sample) begin
      rx_word <= {rx_word[RX_W-2:0], rx_bit};
    end
  end

  assign tx_bit = tx_q[TX_W-1];

  assert_load_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift && !sample);

  assert_edges_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && sample));

endmodule

// File: rtl/sar_rd_wdog.sv
module sar_rd_wdog #(
  parameter int LIMIT = 15000,
  parameter int W     = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == W'(LIMIT - 1));

  assert_window_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < W'(LIMIT));

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader #(
  parameter int DIV_W   = 10,
  parameter int GAP_W   = 12,
  parameter int OUT_W   = 16,
  parameter int TMO_CYC = 15000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [sar_rd_pkg::CH_W-1:0] chan,
  input  logic                        single_ended,
  input  logic                        unipolar,
  input  logic                        sext_en,
  input  logic [DIV_W-1:0]            half_div,
  input  logic [GAP_W-1:0]            gap_cycles,
  output logic                        adc_cs_n,
  output logic                        adc_sclk,
  output logic                        adc_din,
  input  logic                        adc_dout,
  output logic                        busy,
  output logic                        done,
  output logic                        tmo_err,
  output logic [OUT_W-1:0]            result
);
  import sar_rd_pkg::*;

  localparam int PAD_W    = OUT_W - CODE_W;
  localparam int TMO_W    = $clog2(TMO_CYC + 1);
  localparam int BIT_W    = $clog2(CMD_W);
  localparam int BYTE_W   = $clog2(BYTES);
  localparam int LAST_BIT = CMD_W - 1;
  localparam int LAST_BYT = BYTES - 1;

  function automatic logic [OUT_W-1:0] widen(input logic [CODE_W-1:0] c,
                                             input logic sx);
    widen = {{PAD_W{sx & c[CODE_W-1]}}, c};
  endfunction

  rd_state_t          state;
  logic [BIT_W-1:0]   bit_idx;
  logic [BYTE_W-1:0]  byte_idx;
  logic [GAP_W-1:0]   gcnt;
  logic [GAP_W-1:0]   gap_r;
  logic [DIV_W-1:0]   half_r;
  logic [CMD_W-1:0]   cmd_r;
  logic               sext_r;
  logic               conv_on;
  logic [FRAME_W-1:0] rx_frame;

  // named events, shared by the datapath and the assertions
  logic tick, accept, rise_ev, fall_ev, byte_end, last_bit, conv_open;
  logic gap_exit, wd_expire, abort;

  assign accept    = (state == ST_IDLE) && start;
  assign rise_ev   = ((state == ST_SETUP) || (state == ST_LOW)) && tick;
  assign fall_ev   = (state == ST_HIGH) && tick;
  assign byte_end  = fall_ev && (bit_idx == BIT_W'(LAST_BIT));
  assign last_bit  = byte_end && (byte_idx == BYTE_W'(LAST_BYT));
  assign conv_open = byte_end && (byte_idx == '0);
  assign gap_exit  = (state == ST_GAP) && (gcnt == gap_r);
  assign abort     = wd_expire && !last_bit;
  assign busy      = (state != ST_IDLE);

  sar_rd_halfgen #(.DIV_W(DIV_W)) half_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  ((state == ST_IDLE) || (state == ST_GAP)),
    .half_len (half_r),
    .tick     (tick)
  );

  sar_rd_shifter #(.TX_W(CMD_W), .RX_W(FRAME_W)) shift_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (mk_cmd(chan, unipolar, single_ended)),
    .shift    (fall_ev),
    .sample   (rise_ev),
    .rx_bit   (adc_dout),
    .tx_bit   (adc_din),
    .rx_word  (rx_frame)
  );

  sar_rd_wdog #(.LIMIT(TMO_CYC), .W(TMO_W)) wdog_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (conv_open),
    .run    (conv_on),
    .expire (wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      byte_idx <= '0;
      gcnt     <= '0;
      gap_r    <= '0;
      half_r   <= '0;
      cmd_r    <= '0;
      sext_r   <= 1'b0;
      conv_on  <= 1'b0;
      adc_cs_n <= 1'b1;
      adc_sclk <= 1'b0;
      done     <= 1'b0;
      tmo_err  <= 1'b0;
      result   <= '0;
    end else begin
      done    <= 1'b0;
      tmo_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            half_r   <= half_div;
            gap_r    <= gap_cycles;
            cmd_r    <= mk_cmd(chan, unipolar, single_ended);
            sext_r   <= sext_en && !unipolar;
            bit_idx  <= '0;
            byte_idx <= '0;
            adc_cs_n <= 1'b0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP, ST_LOW: begin
          if (tick) begin
            adc_sclk <= 1'b1;
            state    <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            adc_sclk <= 1'b0;
            if (bit_idx == BIT_W'(LAST_BIT)) begin
              bit_idx <= '0;
              if (byte_idx == BYTE_W'(LAST_BYT)) begin
                adc_cs_n <= 1'b1;
                done     <= 1'b1;
                result   <= widen(code_of(rx_frame), sext_r);
                state    <= ST_IDLE;
              end else begin
                gcnt  <= '0;
                state <= ST_GAP;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (gap_exit) begin
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_LOW;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (conv_open) begin
        conv_on <= 1'b1;
      end else if (last_bit || abort) begin
        conv_on <= 1'b0;
      end

      if (abort) begin
        state    <= ST_IDLE;
        adc_cs_n <= 1'b1;
        adc_sclk <= 1'b0;
        done     <= 1'b1;
        tmo_err  <= 1'b1;
        result   <= '0;
      end
    end
  end

  assert_din_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk && $past(adc_sclk) |-> $stable(adc_din));

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> adc_cs_n && !adc_sclk);

  assert_sclk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(cmd_r));

  assert_tmo_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> done && (result == '0));

  assert_window_in_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_on |-> busy);

endmodule

// File: tb/sar_adc_reader_tb_top.sv
`timescale 1ns/1ps
module sar_adc_reader_tb_top;

  localparam int TMO = 1000;
  localparam logic [7:0] JUNK = 8'hA5;

  // {chan[3], se, uni, sext, half_div[10], gap[12], code[10]}
  localparam logic [37:0] VECS [6] = '{
    {3'd0, 1'b1, 1'b1, 1'b0, 10'd3, 12'd0,  10'h3FF},
    {3'd5, 1'b0, 1'b0, 1'b1, 10'd3, 12'd5,  10'h200},
    {3'd7, 1'b1, 1'b0, 1'b0, 10'd1, 12'd2,  10'h2AA},
    {3'd2, 1'b0, 1'b1, 1'b1, 10'd7, 12'd9,  10'h155},
    {3'd6, 1'b1, 1'b0, 1'b1, 10'd0, 12'd0,  10'h1FF},
    {3'd1, 1'b0, 1'b1, 1'b0, 10'd2, 12'd40, 10'h000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic single_ended = 1'b0, unipolar = 1'b0, sext_en = 1'b0;
  logic [9:0] half_div = '0;
  logic [11:0] gap_cycles = '0;
  logic adc_cs_n, adc_sclk, adc_din, busy, done, tmo_err;
  logic adc_dout = 1'b0;
  logic [15:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sar_adc_reader #(.DIV_W(10), .GAP_W(12), .OUT_W(16), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .single_ended(single_ended), .unipolar(unipolar), .sext_en(sext_en),
    .half_div(half_div), .gap_cycles(gap_cycles),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .busy(busy), .done(done), .tmo_err(tmo_err),
    .result(result)
  );

  // behavioural converter: shifts on SCLK falls, captures DIN on rises
  logic [15:0] sl_word = '0;
  logic [7:0]  cap = '0;
  int          rcnt = 0;
  int          late_ones = 0;
  time         t_cs = 0, t_r0 = 0, t_r1 = 0;
  logic        sclk_q = 1'b0, cs_q = 1'b1;

  always @(adc_cs_n or adc_sclk) begin
    if (!adc_cs_n && cs_q) begin
      rcnt = 0; late_ones = 0; t_cs = $time;
      adc_dout = JUNK[7];
    end else if (!adc_cs_n && adc_sclk && !sclk_q) begin
      if (rcnt < 8) cap = {cap[6:0], adc_din};
      else if (adc_din) late_ones = late_ones + 1;
      if (rcnt == 0) t_r0 = $time;
      if (rcnt == 1) t_r1 = $time;
      rcnt = rcnt + 1;
    end else if (!adc_cs_n && !adc_sclk && sclk_q) begin
      if (rcnt < 8) adc_dout = JUNK[7-rcnt];
      else if (rcnt < 24) adc_dout = sl_word[23-rcnt];
      else adc_dout = 1'b0;
    end else if (adc_cs_n) begin
      adc_dout = 1'b0;
    end
    sclk_q = adc_sclk;
    cs_q = adc_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [2:0] ch, input logic se, input logic uni,
                         input logic sx, input logic [9:0] hd,
                         input logic [11:0] gp, input logic [9:0] code,
                         input bit poke);
    int h, g, n, exp_n;
    bit exp_tmo;
    logic [15:0] exp_res;
    logic [7:0] exp_cmd;
    h = hd + 1;
    g = gp;
    exp_tmo = (32*h + 2*g + 2) > TMO;
    exp_n = exp_tmo ? (16*h + TMO) : (48*h + 2*g + 2);
    exp_cmd = {1'b1, ch, uni, se, 2'b11};
    exp_res = exp_tmo ? 16'h0 :
              ((!uni && sx) ? {{6{code[9]}}, code} : {6'b0, code});
    sl_word = {1'b0, code, 2'b10, 3'b101};
    @(negedge clk);
    chan = ch; single_ended = se; unipolar = uni; sext_en = sx;
    half_div = hd; gap_cycles = gp; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    chk(busy === 1'b1, "R7", "busy after start", busy, 1);
    n = 0;
    while (done !== 1'b1 && n < exp_n + 50) begin
      @(posedge clk); #2;
      n++;
      if (poke && n == 20) begin
        start = 1'b1; chan = ~ch; unipolar = ~uni;
      end else if (poke && n == 21) begin
        start = 1'b0; chan = ch; unipolar = uni;
      end
    end
    chk(n == exp_n, "R7", "done edge count", n, exp_n);
    chk(busy === 1'b0, "R7", "busy drops with done", busy, 0);
    chk(tmo_err === exp_tmo, "R9", "timeout flag", tmo_err, exp_tmo);
    chk(result === exp_res, exp_tmo ? "R9" : "R5/R6", "result", result, exp_res);
    if (!exp_tmo) begin
      chk(cap === exp_cmd, "R1", "command byte", cap, exp_cmd);
      chk(rcnt == 24, "R4", "rising edges", rcnt, 24);
      chk(late_ones == 0, "R4", "DIN ones in data bytes", late_ones, 0);
      chk((t_r1 - t_r0) == 16*h, "R3", "SCLK period ns", t_r1 - t_r0, 16*h);
      chk((t_r0 - t_cs) == 8*h, "R2", "CS lead ns", t_r0 - t_cs, 8*h);
    end
    @(posedge clk); #2;
    chk(adc_cs_n === 1'b1 && adc_sclk === 1'b0, "R2", "idle pins after txn",
        {adc_cs_n, adc_sclk}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(adc_cs_n === 1'b1, "R10", "cs_n in reset", adc_cs_n, 1);
    chk(adc_sclk === 1'b0 && busy === 1'b0 && done === 1'b0 && tmo_err === 1'b0,
        "R10", "sclk/busy/done/tmo in reset",
        {adc_sclk, busy, done, tmo_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < 6; i++) begin
      run_txn(VECS[i][37:35], VECS[i][34], VECS[i][33], VECS[i][32],
              VECS[i][31:22], VECS[i][21:10], VECS[i][9:0], 1'b0);
    end

    // R8: a second start mid-transaction leaves the command and length alone
    run_txn(3'd3, 1'b1, 1'b1, 1'b0, 10'd3, 12'd4, 10'h0C3, 1'b1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 300; k++) begin
        @(posedge clk); #2;
        if (busy === 1'b1 || done === 1'b1) extra++;
      end
      chk(extra == 0, "R8", "no follow-on transaction", extra, 0);
    end

    // R9: window boundary, 32*4+2*435+2 = 1000 fits; 436 does not
    run_txn(3'd4, 1'b1, 1'b0, 1'b1, 10'd3, 12'd435, 10'h301, 1'b0);
    run_txn(3'd4, 1'b1, 1'b0, 1'b1, 10'd3, 12'd436, 10'h301, 1'b0);
    // recovery after an abort
    run_txn(3'd0, 1'b1, 1'b1, 1'b0, 10'd3, 12'd0, 10'h2C4, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule